// File: doc/BRIEF.md
# ATM Cell Header Check Byte Inserter

This block sits in the transmit path of a cell-based link. Outbound 53-byte ATM cells arrive as a byte stream, with a start-of-cell flag on the first byte of each cell. The block computes the header error control byte over the four leading header octets and writes it into the fifth octet, replacing whatever byte the upstream logic placed there. Every other byte passes through one output register without change.

Three static control bits shape the inserted byte. One enables recalculation. One XORs a fixed coset pattern into the result. One complements all eight bits. The coset and invert bits have an effect only while recalculation is on. With recalculation off, the fifth octet passes through untouched. The block samples the controls on the start-of-cell byte, so a cell never mixes two settings. Both sides use valid/ready handshakes, and the block honours backpressure from downstream.

Top module: `atm_hec_inserter`

## Requirements
- R1: With recalculation enabled, the fifth byte of a cell is CRC-8 of bytes 1 to 4: generator x^8+x^2+x+1, initial value 0x00, most significant bit first, no coset, no inversion (header 00 00 00 01 gives 0x07).
- R2: With recalculation and coset enabled and invert off, the fifth byte is that CRC XOR 0x55.
- R3: With recalculation and invert enabled and coset off, the fifth byte is the bitwise complement of the CRC.
- R4: With all three controls set, the coset is applied first and the inversion second, giving ~(CRC ^ 0x55).
- R5: With recalculation disabled, the fifth byte leaves unchanged, whatever the coset and invert controls hold.
- R6: Bytes 1 to 4 and 6 to 53 of a cell leave unchanged, and out_soc reproduces in_soc byte for byte.
- R7: A byte accepted on a clock edge (in_valid and in_ready high) is presented on out_data with out_valid high right after that edge, and out_valid is low whenever no accepted byte is waiting.
- R8: The controls are captured on the accepted start-of-cell byte. Changing them later in the cell does not alter that cell's fifth byte.
- R9: While out_valid is high and out_ready is low, out_data and out_soc hold and in_ready is low, so no byte is lost or duplicated.
- R10: A byte with in_soc high restarts the count at byte 1, even partway through a cell. Bytes arriving outside a cell (before the first start-of-cell, or after byte 53 with no new start-of-cell) pass through unchanged.
- R11: During and right after the synchronous active-high reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_recalc | input | 1 | Enable computing and inserting the check byte |
| cfg_coset | input | 1 | XOR coset 0x55 into the computed byte |
| cfg_invert | input | 1 | Complement the inserted byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input byte |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can accept a byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is the first byte of a cell |

## Verification
A byte position counter that drifts, or a cell-active flag that clears too early, puts the check byte at the wrong offset or leaves a fifth byte unreplaced. This shows up at the ports in the first cell after the fault, and the next start-of-cell corrects it. A stale CRC register or a wrongly latched control corrupts only the fifth byte, one cycle after it is accepted. A slip in the output register under stall duplicates, drops or changes a byte at the first cycle with out_ready low. The bench compares every output byte with a model, so each of these faults is caught at its first appearance.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic recalc;
    logic coset;
    logic invert;
  } hec_cfg_t;

  // One byte of a CRC-8 shift register, most significant bit first.
  function automatic byte_t crc8_step(byte_t crc_in, byte_t din, byte_t poly);
    byte_t c;
    c = crc_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[BYTE_W-1] ^ din[i]) c = (c << 1) ^ poly;
      else                      c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hec_cell_tracker.sv
module hec_cell_tracker
  import atm_hec_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int POS_W    = $clog2(CELL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             soc,
  input  hec_cfg_t         cfg_in,
  output logic [POS_W-1:0] idx,
  output logic             active,
  output hec_cfg_t         cfg_q
);

  localparam logic [POS_W-1:0] LEN_V = POS_W'(CELL_LEN);

  logic [POS_W-1:0] pos_q;
  logic             in_cell_q;
  logic [POS_W-1:0] idx_next;

  // A start-of-cell byte always resynchronises to byte index 0.
  assign idx      = soc ? '0 : pos_q;
  assign active   = soc | in_cell_q;
  assign idx_next = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      in_cell_q <= 1'b0;
      cfg_q     <= '0;
    end else begin
      if (fire && active) begin
        pos_q     <= idx_next;
        in_cell_q <= (idx_next < LEN_V);
      end
      if (fire && soc) cfg_q <= cfg_in;
    end
  end

  // R10
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LEN_V);

  // R10
  soc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    fire && soc |=> pos_q == POS_W'(1) && in_cell_q);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fire && soc) |=> $stable(cfg_q));

endmodule

// File: rtl/hec_crc_unit.sv
module hec_crc_unit
  import atm_hec_pkg::*;
#(
  parameter int    HDR_LEN = 4,
  parameter int    POS_W   = 6,
  parameter byte_t POLY    = 8'h07,
  parameter byte_t COSET   = 8'h55
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             active,
  input  logic [POS_W-1:0] idx,
  input  byte_t            din,
  input  hec_cfg_t         cfg,
  output byte_t            hec_byte,
  output logic             hec_slot
);

  localparam logic [POS_W-1:0] HDR_V = POS_W'(HDR_LEN);

  byte_t crc_q;
  byte_t crc_seed;
  byte_t with_coset;
  logic  in_hdr;

  assign in_hdr   = active && (idx < HDR_V);
  assign hec_slot = active && (idx == HDR_V);
  assign crc_seed = (idx == '0) ? '0 : crc_q;

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else if (fire && in_hdr) crc_q <= crc8_step(crc_seed, din, POLY);
  end

  // Coset first, inversion second.
  always_comb begin
    with_coset = cfg.coset ? (crc_q ^ COSET) : crc_q;
    hec_byte   = cfg.invert ? ~with_coset : with_coset;
  end

  // R1
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fire && active && idx > HDR_V |=> $stable(crc_q));

endmodule

// File: rtl/hec_out_stage.sv
module hec_out_stage
  import atm_hec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  byte_t d,
  input  logic  soc,
  input  logic  out_ready,
  output logic  out_valid,
  output byte_t out_data,
  output logic  out_soc,
  output logic  can_accept
);

  assign can_accept = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_soc   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d;
      out_soc   <= soc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_soc));

endmodule

// File: rtl/atm_hec_inserter.sv
module atm_hec_inserter
  import atm_hec_pkg::*;
#(
  parameter int    CELL_LEN = 53,
  parameter int    HDR_LEN  = 4,
  parameter byte_t POLY     = 8'h07,
  parameter byte_t COSET    = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_recalc,
  input  logic       cfg_coset,
  input  logic       cfg_invert,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_soc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_soc
);

  localparam int POS_W = $clog2(CELL_LEN + 1);
  localparam logic [POS_W-1:0] HDR_V = POS_W'(HDR_LEN);

  logic             fire;
  logic [POS_W-1:0] idx;
  logic             active;
  hec_cfg_t         cfg_now;
  hec_cfg_t         cfg_q;
  byte_t            hec_byte;
  logic             hec_slot;
  byte_t            byte_sel;

  assign cfg_now = '{recalc: cfg_recalc, coset: cfg_coset, invert: cfg_invert};
  assign fire    = in_valid && in_ready;

  hec_cell_tracker #(.CELL_LEN(CELL_LEN), .POS_W(POS_W)) u_trk (
    .clk(clk), .rst(rst), .fire(fire), .soc(in_soc), .cfg_in(cfg_now),
    .idx(idx), .active(active), .cfg_q(cfg_q)
  );

  hec_crc_unit #(.HDR_LEN(HDR_LEN), .POS_W(POS_W), .POLY(POLY), .COSET(COSET)) u_crc (
    .clk(clk), .rst(rst), .fire(fire), .active(active), .idx(idx),
    .din(in_data), .cfg(cfg_q), .hec_byte(hec_byte), .hec_slot(hec_slot)
  );

  assign byte_sel = (hec_slot && cfg_q.recalc) ? hec_byte : in_data;

  hec_out_stage u_out (
    .clk(clk), .rst(rst), .load(fire), .d(byte_sel), .soc(in_soc),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_soc(out_soc), .can_accept(in_ready)
  );

  // R5
  pass_slot_chk: assert property (@(posedge clk) disable iff (rst)
    fire && hec_slot && !cfg_q.recalc |=> out_data == $past(in_data));

  // R6
  payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
    fire && active && idx > HDR_V |=> out_data == $past(in_data) && out_soc == $past(in_soc));

  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

endmodule

// File: tb/sim_atm_hec_inserter.sv
module sim_atm_hec_inserter;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_recalc, cfg_coset, cfg_invert;
  logic       in_valid, in_ready, in_soc;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_soc;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  atm_hec_inserter u0 (
    .clk(clk), .rst(rst), .cfg_recalc(cfg_recalc), .cfg_coset(cfg_coset),
    .cfg_invert(cfg_invert), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_soc(in_soc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_d[$];
  logic       exp_s[$];
  string      exp_t[$];

  // Bench model state
  int          m_pos = 0;
  bit          m_in_cell = 1'b0;
  logic [31:0] m_hdr = '0;
  bit          m_rc = 0, m_co = 0, m_iv = 0;

  bit         stall_seen = 1'b0;
  logic [7:0] stall_d;
  logic       stall_s;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference check byte via long division by 0x107.
  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r = r ^ (40'h107 << (i - 8));
    return r[7:0];
  endfunction

  task automatic model_push(input logic [7:0] d, input logic s);
    int          idx;
    logic [7:0]  e;
    string       t;
    logic [7:0]  h;
    idx = s ? 0 : m_pos;
    e = d;
    t = "R6";
    if (s) begin
      m_rc = cfg_recalc; m_co = cfg_coset; m_iv = cfg_invert;
    end
    if (!(s || m_in_cell)) begin
      t = "R10";
    end else begin
      if (idx < 4) m_hdr = {m_hdr[23:0], d};
      if (idx == 4) begin
        if (m_rc) begin
          h = ref_crc(m_hdr);
          if (m_co) h = h ^ 8'h55;
          if (m_iv) h = ~h;
          e = h;
          if (m_co && m_iv)  t = "R4";
          else if (m_co)     t = "R2";
          else if (m_iv)     t = "R3";
          else               t = "R1";
        end else begin
          t = "R5";
        end
        if ({cfg_recalc, cfg_coset, cfg_invert} != {m_rc, m_co, m_iv}) t = "R8";
      end
      m_pos = idx + 1;
      m_in_cell = (m_pos < 53);
    end
    exp_d.push_back(e);
    exp_s.push_back(s);
    exp_t.push_back(t);
  endtask

  // Evaluate one cycle with inputs already driven; then advance to next negedge.
  task automatic eval(output bit acc);
    logic [7:0] ed;
    logic       es;
    string      et;
    #1;
    if (stall_seen)  // R9: held output
      chk(out_valid && out_data == stall_d && out_soc == stall_s, "R9", out_data, stall_d);
    stall_seen = out_valid && !out_ready;
    if (stall_seen) begin
      stall_d = out_data;
      stall_s = out_soc;
      chk(in_ready == 1'b0, "R9", in_ready, 0);
    end
    // R7: output valid exactly when an accepted byte is pending
    chk(out_valid == (exp_d.size() > 0), "R7", out_valid, exp_d.size() > 0);
    if (out_valid && out_ready && exp_d.size() > 0) begin
      ed = exp_d.pop_front();
      es = exp_s.pop_front();
      et = exp_t.pop_front();
      chk(out_data == ed, et, out_data, ed);
      chk(out_soc == es, "R6", out_soc, es);
    end
    acc = in_valid && in_ready;
    if (acc) model_push(in_data, in_soc);
    @(negedge clk);
  endtask

  task automatic idle(input int pct);
    bit a;
    in_valid  = 1'b0;
    in_soc    = 1'($urandom);
    in_data   = 8'($urandom);
    out_ready = ($urandom % 100) < pct;
    eval(a);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input int pct);
    bit a;
    do begin
      in_valid  = 1'b1;
      in_data   = d;
      in_soc    = s;
      out_ready = ($urandom % 100) < pct;
      eval(a);
    end while (!a);
  endtask

  task automatic send_cell(input logic [31:0] hdr, input int len, input bit flip,
                           input int pct, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle(pct);
      if (flip && i == 2) begin
        cfg_recalc = 1'($urandom); cfg_coset = 1'($urandom); cfg_invert = 1'($urandom);
      end
      send_byte(i < 4 ? hdr[31 - 8*i -: 8] : 8'($urandom), i == 0, pct);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    in_valid = 1'b0; in_data = '0; in_soc = 1'b0; out_ready = 1'b0;
    cfg_recalc = 1'b0; cfg_coset = 1'b0; cfg_invert = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", out_valid, 0);  // R11 during reset
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R11", out_valid, 0);  // R11 after reset
    chk(ref_crc(32'h00000001) == 8'h07, "R1", ref_crc(32'h00000001), 8'h07);
    @(negedge clk);

    // R10: stray bytes before any start-of-cell
    for (int i = 0; i < 5; i++) send_byte(8'($urandom), 1'b0, 100);

    // Directed: every control combination on two fixed headers
    for (int c = 0; c < 8; c++) begin
      {cfg_recalc, cfg_coset, cfg_invert} = 3'(c);
      send_cell(32'h00000000, 53, 1'b0, 100, 1'b0);
      send_cell(32'h00000001, 53, 1'b0, 100, 1'b0);
    end

    // R10: truncated cell, then bytes after a full cell without a new start
    cfg_recalc = 1'b1; cfg_coset = 1'b1; cfg_invert = 1'b0;
    send_cell(32'hDEADBEEF, 3, 1'b0, 100, 1'b0);
    send_cell(32'h12345678, 53, 1'b0, 100, 1'b0);
    for (int i = 0; i < 6; i++) send_byte(8'($urandom), 1'b0, 100);

    // R8: forced control change mid-cell
    cfg_recalc = 1'b1; cfg_coset = 1'b0; cfg_invert = 1'b0;
    for (int i = 0; i < 53; i++) begin
      if (i == 2) begin cfg_recalc = 1'b0; cfg_coset = 1'b1; cfg_invert = 1'b1; end
      send_byte(i < 4 ? 8'(8'hA0 + i) : 8'($urandom), i == 0, 100);
    end

    // Random cells with gaps, backpressure, control flips and truncations
    for (int n = 0; n < 40; n++) begin
      cfg_recalc = 1'($urandom); cfg_coset = 1'($urandom); cfg_invert = 1'($urandom);
      send_cell($urandom, ($urandom % 8 == 0) ? int'($urandom % 53) : 53,
                ($urandom % 3 == 0), 60, 1'b1);
      if ($urandom % 5 == 0) send_byte(8'($urandom), 1'b0, 60);
    end

    // Drain
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      out_ready = 1'b1;
      eval(a);
    end
    chk(exp_d.size() == 0, "R7", exp_d.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule